// File: doc/BRIEF.md
# Signed/Unsigned Bitfield Extract Unit

This execution unit sits in a shader-style datapath. It pulls an N-bit field out of a source word, starting at a chosen bit offset, and returns that field zero-extended or sign-extended. It has three operating modes.

- **32-bit scalar and 64-bit scalar.** The offset and the width come packed in one 32-bit control word. These modes also produce a condition flag that reports whether the result is nonzero.
- **Lane mode.** Several 32-bit lanes run side by side. Each lane takes its offset and its width from two separate per-lane operands. An execute mask decides which lanes are written.

Operations enter on a valid/ready stream and leave on a registered valid/ready stream one cycle later. The output stage is a single register slot:

- An input is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high when the slot is empty, or when the consumer takes the held result in that same cycle.
- While `out_valid` is high and `out_ready` is low, every output holds still and no new operation is accepted.

The scalar result register and the lane result registers are separate destinations. An operation of one kind never disturbs the other destination.

Top module: `bfx_unit`

## Requirements
- R1: For an unsigned operation, the result is the source shifted right by the offset, with every bit at position N and above cleared, where N is the field width.
- R2: Mode code 0 is 32-bit scalar: offset = `in_ctrl[4:0]`, width = `in_ctrl[22:16]`, and only `in_src[31:0]` is used. The result occupies `out_sdata[31:0]`, and `out_sdata[63:32]` reads 0.
- R3: Mode code 1 is 64-bit scalar: offset = `in_ctrl[5:0]`, width = `in_ctrl[22:16]`, and all 64 bits of `in_src` are used.
- R4: When `in_signed` is 1 and bit N-1 of the extracted field is 1, every result bit from N up to the top of the data width is 1. Otherwise those bits are 0.
- R5: After a scalar operation, `out_scc` is 1 when `out_sdata` is nonzero and 0 when it is zero.
- R6: Mode code 2 is lane mode. Lane i uses source `in_vsrc[32i+31:32i]`, offset `in_voff[32i+4:32i]` and width `in_vwid[32i+4:32i]`, and writes `out_vdata[32i+31:32i]`.
- R7: In lane mode, a lane is written only when bit i of `in_exec` is 1. A masked-off lane keeps its previous value. Lane operations leave `out_sdata`/`out_scc` unchanged, and scalar operations leave `out_vdata` unchanged.
- R8: A width of 0 gives a result of 0 with no sign extension, and in the scalar modes it clears `out_scc`.
- R9: A width equal to or greater than the data width (32 or 64) returns the shifted source with no masking.
- R10: An input accepted at a clock edge is reflected in `out_valid` = 1 and in the result registers right after that edge, with `out_mode` equal to its mode code.
- R11: `in_ready` = 0 exactly while `out_valid` = 1 and `out_ready` = 0. During such a stall all outputs hold their values.
- R12: A synchronous active-high `rst` clears `out_valid`, `out_mode`, `out_sdata`, `out_scc` and `out_vdata` to 0.
- R13: Mode code 3 is a no-op. It is accepted and raises `out_valid`, but it changes no result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_mode | input | 2 | 0 = 32-bit scalar, 1 = 64-bit scalar, 2 = lane mode, 3 = no-op |
| in_signed | input | 1 | 1 = sign-extend the field |
| in_src | input | 64 | Scalar source word |
| in_ctrl | input | 32 | Scalar control: offset and width fields |
| in_vsrc | input | 32*LANES | Per-lane source words |
| in_voff | input | 32*LANES | Per-lane offset operands |
| in_vwid | input | 32*LANES | Per-lane width operands |
| in_exec | input | LANES | Lane execute mask |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the result |
| out_mode | output | 2 | Mode code of the last accepted operation |
| out_sdata | output | 64 | Scalar result register |
| out_scc | output | 1 | Scalar nonzero flag |
| out_vdata | output | 32*LANES | Lane result registers |

## Verification
The assertions make two assumptions about the environment:

- `rst` is held for at least one clock edge before any input is offered.
- The input fields are stable, known values whenever `in_valid` is high.

The hold-during-stall checks also rely on the consumer not dropping the stream mid-transfer. The stimulus meets these assumptions by changing inputs only at falling edges and by raising `out_ready` only after a stall has been observed.

The field widths used by the stimulus go beyond the data width only in the scalar modes. They are chosen so that the zero, exactly-full and oversized cases are each reached.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int NARROW_W = 32;
  localparam int WIDE_W   = 64;
  localparam int CTRL_W   = 32;

  typedef enum logic [1:0] {
    BFX_S32 = 2'd0,
    BFX_S64 = 2'd1,
    BFX_VEC = 2'd2,
    BFX_NOP = 2'd3
  } bfx_mode_e;
endpackage

// File: rtl/bfx_field.sv
module bfx_field #(
  parameter int DW   = 32,
  parameter int OFFW = 5,
  parameter int WIDW = 7
) (
  input  logic [DW-1:0]   src,
  input  logic [OFFW-1:0] off,
  input  logic [WIDW-1:0] wid,
  input  logic            sgn,
  output logic [DW-1:0]   res
);
  logic [DW-1:0] shifted;
  logic [DW-1:0] keep;
  logic [DW-1:0] top_bit;
  logic          neg;
  logic          full;

  always_comb begin
    shifted = src >> off;
    full    = (int'(wid) >= DW);
    if (wid == '0)   keep = '0;
    else if (full)   keep = '1;
    else             keep = ~({DW{1'b1}} << wid);
    top_bit = keep ^ (keep >> 1);
    neg     = sgn && (|(shifted & top_bit));
    res     = (shifted & keep) | (neg ? ~keep : '0);
  end

  // R8
  always_comb begin
    if (wid == '0) zero_width_chk: assert (res == '0);
  end
endmodule

// File: rtl/bfx_scalar_path.sv
module bfx_scalar_path
  import bfx_pkg::*;
(
  input  logic [WIDE_W-1:0] src,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              is_wide,
  input  logic              sgn,
  output logic [WIDE_W-1:0] res,
  output logic              nonzero
);
  localparam int NOFF = $clog2(NARROW_W);
  localparam int WOFF = $clog2(WIDE_W);
  localparam int WIDF = 7;
  localparam int WLO  = 16;

  logic [NARROW_W-1:0] r_narrow;
  logic [WIDE_W-1:0]   r_wide;
  logic                unused_ctrl;

  assign unused_ctrl = ^{ctrl[CTRL_W-1:WLO+WIDF], ctrl[WLO-1:WOFF]};

  bfx_field #(.DW(NARROW_W), .OFFW(NOFF), .WIDW(WIDF)) u_narrow (
    .src(src[NARROW_W-1:0]), .off(ctrl[NOFF-1:0]),
    .wid(ctrl[WLO+WIDF-1:WLO]), .sgn(sgn), .res(r_narrow)
  );

  bfx_field #(.DW(WIDE_W), .OFFW(WOFF), .WIDW(WIDF)) u_wide (
    .src(src), .off(ctrl[WOFF-1:0]),
    .wid(ctrl[WLO+WIDF-1:WLO]), .sgn(sgn), .res(r_wide)
  );

  always_comb begin
    res     = is_wide ? r_wide : {{(WIDE_W-NARROW_W){1'b0}}, r_narrow};
    nonzero = |res;
  end
endmodule

// File: rtl/bfx_vector_path.sv
module bfx_vector_path
  import bfx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES*NARROW_W-1:0] vsrc,
  input  logic [LANES*NARROW_W-1:0] voff,
  input  logic [LANES*NARROW_W-1:0] vwid,
  input  logic                      sgn,
  output logic [LANES*NARROW_W-1:0] vres
);
  localparam int FW = $clog2(NARROW_W);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic unused_hi;
    assign unused_hi = ^{voff[i*NARROW_W+FW +: NARROW_W-FW],
                         vwid[i*NARROW_W+FW +: NARROW_W-FW]};
    bfx_field #(.DW(NARROW_W), .OFFW(FW), .WIDW(FW)) u_lane (
      .src(vsrc[i*NARROW_W +: NARROW_W]),
      .off(voff[i*NARROW_W +: FW]),
      .wid(vwid[i*NARROW_W +: FW]),
      .sgn(sgn),
      .res(vres[i*NARROW_W +: NARROW_W])
    );
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [1:0]                in_mode,
  input  logic                      in_signed,
  input  logic [63:0]               in_src,
  input  logic [31:0]               in_ctrl,
  input  logic [LANES*32-1:0]       in_vsrc,
  input  logic [LANES*32-1:0]       in_voff,
  input  logic [LANES*32-1:0]       in_vwid,
  input  logic [LANES-1:0]          in_exec,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [1:0]                out_mode,
  output logic [63:0]               out_sdata,
  output logic                      out_scc,
  output logic [LANES*32-1:0]       out_vdata
);
  localparam int VBITS = LANES * NARROW_W;

  bfx_mode_e        mode;
  logic             fire;
  logic [63:0]      s_res;
  logic             s_nz;
  logic [VBITS-1:0] v_res;

  assign mode     = bfx_mode_e'(in_mode);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  bfx_scalar_path u_scalar (
    .src(in_src), .ctrl(in_ctrl), .is_wide(mode == BFX_S64),
    .sgn(in_signed), .res(s_res), .nonzero(s_nz)
  );

  bfx_vector_path #(.LANES(LANES)) u_vector (
    .vsrc(in_vsrc), .voff(in_voff), .vwid(in_vwid),
    .sgn(in_signed), .vres(v_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mode  <= 2'd0;
      out_sdata <= '0;
      out_scc   <= 1'b0;
      out_vdata <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (fire) begin
        out_mode <= in_mode;
        unique case (mode)
          BFX_S32, BFX_S64: begin
            out_sdata <= s_res;
            out_scc   <= s_nz;
          end
          BFX_VEC: begin
            for (int i = 0; i < LANES; i++)
              if (in_exec[i]) out_vdata[i*NARROW_W +: NARROW_W] <= v_res[i*NARROW_W +: NARROW_W];
          end
          default: ;
        endcase
      end
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_sdata) && $stable(out_vdata) && $stable(out_scc));

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && out_mode == $past(in_mode));

  // R5
  scc_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_mode == BFX_S32 || out_mode == BFX_S64) |-> out_scc == (out_sdata != '0));

  // R2
  s32_upper_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_mode == BFX_S32 |-> out_sdata[63:32] == '0);

  // R13
  nop_keep_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_mode == BFX_NOP |=> $stable(out_sdata) && $stable(out_vdata) && $stable(out_scc));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    // R7
    lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && (in_mode != BFX_VEC || !in_exec[i])
        |=> $stable(out_vdata[i*NARROW_W +: NARROW_W]));
  end
endmodule

// File: tb/bfx_unit_tb_top.sv
module bfx_unit_tb_top;
  localparam int LANES = 4;
  localparam int VB = LANES * 32;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, in_signed, out_valid, out_ready, out_scc;
  logic [1:0] in_mode, out_mode;
  logic [63:0] in_src, out_sdata;
  logic [31:0] in_ctrl;
  logic [VB-1:0] in_vsrc, in_voff, in_vwid, out_vdata;
  logic [LANES-1:0] in_exec;

  int n_checks = 0;
  int n_fail   = 0;
  logic [VB-1:0] lane_exp;

  always #10 clk = ~clk;

  bfx_unit #(.LANES(LANES)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_signed(in_signed), .in_src(in_src), .in_ctrl(in_ctrl),
    .in_vsrc(in_vsrc), .in_voff(in_voff), .in_vwid(in_vwid), .in_exec(in_exec),
    .out_valid(out_valid), .out_ready(out_ready), .out_mode(out_mode),
    .out_sdata(out_sdata), .out_scc(out_scc), .out_vdata(out_vdata)
  );

  task automatic check(input string req, input logic [VB-1:0] act, input logic [VB-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] src, input int off,
                                        input int wid, input int dw, input logic sgn);
    logic [63:0] r;
    int n;
    r = '0;
    if (wid == 0) return r;
    n = (wid > dw) ? dw : wid;
    for (int i = 0; i < dw; i++)
      if (i < n && i + off < dw) r[i] = src[i + off];
    if (sgn && r[n-1])
      for (int i = n; i < dw; i++) r[i] = 1'b1;
    return r;
  endfunction

  task automatic issue(input logic [1:0] m, input logic sg, input logic [63:0] s, input logic [31:0] c);
    @(negedge clk);
    in_mode = m; in_signed = sg; in_src = s; in_ctrl = c; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic scalar_case(input string req, input logic [1:0] m, input logic sg,
                             input logic [63:0] s, input int off, input int wid);
    logic [63:0] exp;
    issue(m, sg, s, {9'd0, 7'(wid), 10'd0, 6'(off)});
    exp = (m == 2'd1) ? model(s, off, wid, 64, sg) : model({32'd0, s[31:0]}, off % 32, wid, 32, sg);
    check(req, {64'd0, out_sdata}, {64'd0, exp});
    check({req, " R5 flag"}, {127'd0, out_scc}, {127'd0, exp != 0});
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; in_mode = 2'd0; in_signed = 1'b0;
    in_src = '0; in_ctrl = '0; in_vsrc = '0; in_voff = '0; in_vwid = '0; in_exec = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 valid", {127'd0, out_valid}, '0);
    check("R12 sdata", {64'd0, out_sdata}, '0);
    check("R12 vdata", out_vdata, '0);
    check("R11 ready idle", {127'd0, in_ready}, {127'd0, 1'b1});
    rst = 1'b0;
    lane_exp = '0;
  endtask

  task automatic t_scalar32();
    scalar_case("R1 s32 unsigned", 2'd0, 1'b0, 64'hDEAD_BEEF_0000_0F00, 8, 4);
    check("R1 s32 value", {64'd0, out_sdata}, {64'd0, 64'h0000_0000_0000_000F});
    check("R10 valid", {127'd0, out_valid}, {127'd0, 1'b1});
    check("R10 mode", {126'd0, out_mode}, '0);
    scalar_case("R4 s32 signed", 2'd0, 1'b1, 64'h0000_0000_0000_0F00, 8, 4);
    check("R2 upper zero", {64'd0, out_sdata}, {64'd0, 64'h0000_0000_FFFF_FFFF});
    scalar_case("R4 s32 positive", 2'd0, 1'b1, 64'h0000_0000_1234_5670, 4, 12);
    scalar_case("R2 s32 off 31", 2'd0, 1'b1, 64'h0000_0000_8000_0000, 31, 1);
  endtask

  task automatic t_scalar64();
    scalar_case("R3 s64 signed", 2'd1, 1'b1, 64'h8000_0000_0000_0000, 60, 4);
    check("R3 s64 value", {64'd0, out_sdata}, {64'd0, 64'hFFFF_FFFF_FFFF_FFF8});
    scalar_case("R3 s64 unsigned", 2'd1, 1'b0, 64'hA5A5_1234_5678_9ABC, 36, 20);
    scalar_case("R3 s64 mid", 2'd1, 1'b1, 64'h0000_00F0_0000_0000, 38, 3);
  endtask

  task automatic t_widths();
    scalar_case("R8 s32 width0", 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 3, 0);
    check("R8 zero", {64'd0, out_sdata}, '0);
    scalar_case("R8 s64 width0", 2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    scalar_case("R9 s32 width32", 2'd0, 1'b1, 64'h0000_0000_8000_0001, 0, 32);
    check("R9 s32 pass", {64'd0, out_sdata}, {64'd0, 64'h0000_0000_8000_0001});
    scalar_case("R9 s32 width100", 2'd0, 1'b0, 64'h0000_0000_F000_0000, 4, 100);
    scalar_case("R9 s64 width127", 2'd1, 1'b1, 64'hF000_0000_0000_0000, 8, 127);
    check("R9 s64 pass", {64'd0, out_sdata}, {64'd0, 64'h00F0_0000_0000_0000});
  endtask

  task automatic lane_op(input logic sg, input logic [LANES-1:0] ex);
    @(negedge clk);
    in_mode = 2'd2; in_signed = sg; in_exec = ex; in_valid = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      in_vsrc[i*32 +: 32] = 32'hF0F0_0000 ^ (32'h1357_9BDF * (i + 1));
      in_voff[i*32 +: 32] = 32'hFFFF_FFE0 | (3 * i + 1);
      in_vwid[i*32 +: 32] = 32'h0000_0100 | (5 * i + 2);
    end
    for (int i = 0; i < LANES; i++)
      if (ex[i])
        lane_exp[i*32 +: 32] = model({32'd0, in_vsrc[i*32 +: 32]}, 3 * i + 1, 5 * i + 2, 32, sg);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_lanes();
    logic [63:0] s_before;
    s_before = out_sdata;
    lane_op(1'b1, 4'b0101);
    check("R6 lanes signed", out_vdata, lane_exp);
    check("R7 scalar kept", {64'd0, out_sdata}, {64'd0, s_before});
    lane_op(1'b0, 4'b1010);
    check("R7 mask keeps", out_vdata, lane_exp);
    lane_op(1'b1, 4'b0000);
    check("R7 none written", out_vdata, lane_exp);
    scalar_case("R7 scalar op", 2'd0, 1'b0, 64'h0000_0000_0000_00FF, 0, 8);
    check("R7 lanes kept", out_vdata, lane_exp);
  endtask

  task automatic t_nop();
    logic [63:0] s_before;
    s_before = out_sdata;
    issue(2'd3, 1'b1, 64'h1111_2222_3333_4444, 32'h0010_0000);
    check("R13 valid", {127'd0, out_valid}, {127'd0, 1'b1});
    check("R13 sdata", {64'd0, out_sdata}, {64'd0, s_before});
    check("R13 vdata", out_vdata, lane_exp);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    issue(2'd0, 1'b0, 64'h0000_0000_0000_00AB, {9'd0, 7'd8, 16'd0});
    check("R11 stall ready", {127'd0, in_ready}, '0);
    in_mode = 2'd0; in_signed = 1'b0; in_src = 64'h0000_0000_0000_CD00;
    in_ctrl = {9'd0, 7'd8, 10'd0, 6'd8}; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R11 held", {64'd0, out_sdata}, {64'd0, 64'h0000_0000_0000_00AB});
    check("R11 valid held", {127'd0, out_valid}, {127'd0, 1'b1});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 next taken", {64'd0, out_sdata}, {64'd0, 64'h0000_0000_0000_00CD});
    @(posedge clk);
    @(negedge clk);
    check("R11 drained", {127'd0, out_valid}, '0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_scalar32();
    t_scalar64();
    t_widths();
    t_lanes();
    t_nop();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule